// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block is a synchronous sequencer. It sits between a simple word-request host bus and a 32-bit-wide asynchronous DRAM array with one million words. The array takes its address over ten multiplexed pins: first the row, which is strobed in by the active-low row strobe, then the column, which is strobed in by the active-low column strobes. There is one column strobe for each of the four byte lanes.

The host sends a request with a valid/ready handshake. Each request carries a 20-bit word address, a write flag, four byte enables and 32 bits of write data. A read returns its data with a one-cycle valid pulse.

After an access the controller leaves the row open. A later request to the same row is then served as a fast page cycle, without a new row strobe.

The row is closed, and the required row precharge applied, in three cases:
- a request targets a different row;
- the row-active limit approaches;
- a separate scheduler raises a refresh request.

A refresh request is honoured only once the row is closed. It is then carried out as a column-before-row refresh. Every analog timing minimum is a parameter counted in clock cycles. The defaults assume a 5 ns clock and the 60 ns speed grade.

The state machine has seven states:
- **ST_IDLE**: the row is closed. It goes to ST_REF_SETUP on a refresh request, otherwise to ST_ROW_OPEN on a host request.
- **ST_ROW_OPEN**: the row strobe is low and the row address is driven. After the row-to-column delay it goes to ST_COL.
- **ST_COL**: the column strobes are low, and the access happens here. After the strobe width, and for reads after the row access time, it goes to ST_PAGE.
- **ST_PAGE**: the row is open and the column strobes are precharging. It returns to ST_COL on an accepted same-row request. It goes to ST_PRECHARGE on a row miss, a refresh request or the row-age limit, once the minimum row-active width has passed.
- **ST_PRECHARGE**: the row strobe is high. It returns to ST_IDLE after the precharge time and the random cycle time.
- **ST_REF_SETUP**: all column strobes are low and the row strobe is high. After the setup time it goes to ST_REF_ACTIVE.
- **ST_REF_ACTIVE**: the row strobe is also low. After the minimum row-active width it goes to ST_PRECHARGE.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset the row strobe is high, all four column strobes are high, the write-enable strobe is high, the data output enable is low, the read-valid pulse is low and host_ready is high while no refresh is requested.
- R2: The address bus carries host_addr[19:10] when the row strobe falls for a host access. It carries host_addr[9:0] when a column strobe falls. The same 20-bit address reads back the data last written to it.
- R3: A column strobe falls no fewer than T_RCD cycles after the row strobe fell for the same row.
- R4: Column strobe bit i covers data bits 8i+7..8i. A write pulls low exactly the strobes whose host_be bit is 1, so only those bytes change in the array. A read pulls low all four strobes.
- R5: Every write is an early write. The write-enable strobe is low when the column strobes fall and stays low while they are low, and the data output enable is high only during write column cycles. For reads the write-enable strobe stays high.
- R6: Read data is returned with host_rvalid as a one-cycle pulse. The data is captured no earlier than T_RAC cycles after the row strobe fell and T_CAS_RD cycles after the column strobe fell.
- R7: A request to the row that is currently open is served without any new falling edge of the row strobe.
- R8: A request to a different row closes the open row, applies precharge, and opens the new row with a single new falling edge of the row strobe.
- R9: The row strobe stays low for at least T_RAS cycles and high for at least T_RP cycles. Consecutive falling edges are at least T_RC cycles apart.
- R10: Within one open row, consecutive column-strobe falls are at least T_PC cycles apart, and the column strobes stay high at least T_CP cycles between accesses.
- R11: The row strobe never stays low for T_RASP_MAX cycles or more. An open row that sees no requests is closed by the controller on its own.
- R12: ref_ack is a one-cycle pulse given only while the row is closed. It marks the start of a refresh, in which all column strobes fall at least T_CRS cycles before the row strobe falls. host_ready is low while ref_req is pending.
- R13: A refresh request that arrives while a page is open first closes the row, then performs the refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Controller accepts the request this cycle |
| host_addr | input | 20 | Word address, row in the upper 10 bits |
| host_we | input | 1 | 1 = write, 0 = read |
| host_be | input | 4 | Byte enables for writes, bit i = byte i |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | One-cycle pulse with read data |
| host_rdata | output | 32 | Read data |
| ref_req | input | 1 | Refresh request from the scheduler, held until acknowledged |
| ref_ack | output | 1 | Refresh cycle begins |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 4 | Active-low column strobes, one per byte lane |
| dram_we_n | output | 1 | Active-low write enable |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 32 | Data driven toward the array |
| dram_dq_oe | output | 1 | Output enable for the shared data pins |
| dram_dq_in | input | 32 | Data returned from the array |

## Verification
The hardest conditions to reach from the ports are the self-initiated row close when the row-age limit runs out, and a refresh request that lands while a page is still open. The bench builds the controller with a short row-age limit and then leaves an open row untouched for longer than that limit. It issues a refresh straight after a read, while the page is still held open. The strobe timing monitor measures every edge-to-edge interval against the cycle parameters. A behavioural array model, which latches row and column on strobe edges, makes byte-lane and address-multiplexing mistakes visible as data mismatches.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_COL,
        ST_PAGE,
        ST_PRECHARGE,
        ST_REF_SETUP,
        ST_REF_ACTIVE
    } fpm_state_e;

    function automatic int fpm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_step_timer.sv
module fpm_step_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_age_counter.sv
module fpm_age_counter #(
    parameter int W   = 8,
    parameter int SAT = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] SAT_V = W'(SAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= '0;
        else if (clr)
            age <= '0;
        else if (age != SAT_V)
            age <= age + 1'b1;
    end
endmodule

// File: rtl/fpm_row_track.sv
module fpm_row_track #(
    parameter int RW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [RW-1:0] row_in,
    input  logic [RW-1:0] cmp_row,
    output logic [RW-1:0] open_row,
    output logic          hit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            open_row <= '0;
        else if (load)
            open_row <= row_in;
    end

    assign hit = (cmp_row == open_row);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int COL_W      = 10,
    parameter int DQ_W       = 32,
    parameter int T_RCD      = 4,
    parameter int T_RP       = 8,
    parameter int T_RAS      = 12,
    parameter int T_RC       = 22,
    parameter int T_RAC      = 12,
    parameter int T_CAS_RD   = 6,
    parameter int T_CAS_WR   = 3,
    parameter int T_CP       = 2,
    parameter int T_PC       = 8,
    parameter int T_CRS      = 2,
    parameter int T_RASP_MAX = 20000
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      host_valid,
    output logic                                      host_ready,
    input  logic [ADDR_W-1:0]                         host_addr,
    input  logic                                      host_we,
    input  logic [DQ_W/8-1:0]                         host_be,
    input  logic [DQ_W-1:0]                           host_wdata,
    output logic                                      host_rvalid,
    output logic [DQ_W-1:0]                           host_rdata,
    input  logic                                      ref_req,
    output logic                                      ref_ack,
    output logic                                      dram_ras_n,
    output logic [DQ_W/8-1:0]                         dram_cas_n,
    output logic                                      dram_we_n,
    output logic [fpm_max(ADDR_W-COL_W, COL_W)-1:0]   dram_addr,
    output logic [DQ_W-1:0]                           dram_dq_out,
    output logic                                      dram_dq_oe,
    input  logic [DQ_W-1:0]                           dram_dq_in
);
    localparam int ROW_W   = ADDR_W - COL_W;
    localparam int LANES   = DQ_W / 8;
    localparam int MUX_W   = fpm_max(ROW_W, COL_W);
    localparam int TMAX    = fpm_max(fpm_max(T_RCD, T_RP),
                             fpm_max(fpm_max(T_CAS_RD, T_CAS_WR), fpm_max(T_CP, T_CRS)));
    localparam int TW      = $clog2(TMAX + 1);
    localparam int AGE_SAT = T_RASP_MAX + T_RC;
    localparam int AW      = $clog2(AGE_SAT + 1);
    localparam int CW      = $clog2(T_PC + 1);
    localparam int EXP_AT  = T_RASP_MAX - T_PC - T_CAS_RD - 4;

    localparam logic [AW-1:0] AGE_RAS = AW'(T_RAS - 1);
    localparam logic [AW-1:0] AGE_RC  = AW'(T_RC - 1);
    localparam logic [AW-1:0] AGE_RAC = AW'(T_RAC - 1);
    localparam logic [AW-1:0] AGE_EXP = AW'(EXP_AT);
    localparam logic [CW-1:0] COL_PC  = CW'(T_PC - 1);
    localparam logic [TW-1:0] LD_RCD  = TW'(T_RCD - 1);
    localparam logic [TW-1:0] LD_RP   = TW'(T_RP - 1);
    localparam logic [TW-1:0] LD_CRD  = TW'(T_CAS_RD - 1);
    localparam logic [TW-1:0] LD_CWR  = TW'(T_CAS_WR - 1);
    localparam logic [TW-1:0] LD_CP   = TW'(T_CP - 1);
    localparam logic [TW-1:0] LD_CRS  = TW'(T_CRS - 1);
    localparam logic [LANES-1:0] ALL_HI = {LANES{1'b1}};

    fpm_state_e state_q, state_d;

    logic             step_load, step_done;
    logic [TW-1:0]    step_val;
    logic             age_clr, col_clr;
    logic [AW-1:0]    ras_age;
    logic [CW-1:0]    col_age;
    logic             row_load, row_hit;
    logic [ROW_W-1:0] open_row;
    logic             rd_cap;

    logic [COL_W-1:0] op_col;
    logic             op_we;
    logic [LANES-1:0] op_be;
    logic [DQ_W-1:0]  op_wdata;

    logic expire, close_ok, col_ok, accept;

    fpm_step_timer #(.W(TW)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (step_load),
        .load_val (step_val),
        .done     (step_done)
    );

    fpm_age_counter #(.W(AW), .SAT(AGE_SAT)) u_ras_age (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (age_clr),
        .age   (ras_age)
    );

    fpm_age_counter #(.W(CW), .SAT(T_PC)) u_col_age (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (col_clr),
        .age   (col_age)
    );

    fpm_row_track #(.RW(ROW_W)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (row_load),
        .row_in   (host_addr[ADDR_W-1:COL_W]),
        .cmp_row  (host_addr[ADDR_W-1:COL_W]),
        .open_row (open_row),
        .hit      (row_hit)
    );

    assign expire   = (ras_age >= AGE_EXP);
    assign close_ok = (ras_age >= AGE_RAS);
    assign col_ok   = step_done && (col_age >= COL_PC);

    // handshake toward the host
    always_comb begin
        unique case (state_q)
            ST_IDLE: host_ready = !ref_req;
            ST_PAGE: host_ready = col_ok && !ref_req && !expire && row_hit;
            default: host_ready = 1'b0;
        endcase
    end

    assign accept  = host_valid && host_ready;
    assign ref_ack = (state_q == ST_IDLE) && ref_req;

    // next state and timer loads
    always_comb begin
        state_d   = state_q;
        step_load = 1'b0;
        step_val  = '0;
        age_clr   = 1'b0;
        col_clr   = 1'b0;
        row_load  = 1'b0;
        rd_cap    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req) begin
                    state_d   = ST_REF_SETUP;
                    step_load = 1'b1;
                    step_val  = LD_CRS;
                end else if (host_valid) begin
                    state_d   = ST_ROW_OPEN;
                    step_load = 1'b1;
                    step_val  = LD_RCD;
                    age_clr   = 1'b1;
                    row_load  = 1'b1;
                end
            end
            ST_ROW_OPEN: begin
                if (step_done) begin
                    state_d   = ST_COL;
                    step_load = 1'b1;
                    step_val  = op_we ? LD_CWR : LD_CRD;
                    col_clr   = 1'b1;
                end
            end
            ST_COL: begin
                if (step_done && (op_we || ras_age >= AGE_RAC)) begin
                    state_d   = ST_PAGE;
                    step_load = 1'b1;
                    step_val  = LD_CP;
                    rd_cap    = !op_we;
                end
            end
            ST_PAGE: begin
                if (accept) begin
                    state_d   = ST_COL;
                    step_load = 1'b1;
                    step_val  = host_we ? LD_CWR : LD_CRD;
                    col_clr   = 1'b1;
                end else if ((expire || ref_req || (host_valid && !row_hit)) && close_ok) begin
                    state_d   = ST_PRECHARGE;
                    step_load = 1'b1;
                    step_val  = LD_RP;
                end
            end
            ST_PRECHARGE: begin
                if (step_done && ras_age >= AGE_RC)
                    state_d = ST_IDLE;
            end
            ST_REF_SETUP: begin
                if (step_done) begin
                    state_d = ST_REF_ACTIVE;
                    age_clr = 1'b1;
                end
            end
            ST_REF_ACTIVE: begin
                if (close_ok) begin
                    state_d   = ST_PRECHARGE;
                    step_load = 1'b1;
                    step_val  = LD_RP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // operation latch and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_col      <= '0;
            op_we       <= 1'b0;
            op_be       <= '0;
            op_wdata    <= '0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            if (accept) begin
                op_col   <= host_addr[COL_W-1:0];
                op_we    <= host_we;
                op_be    <= host_be;
                op_wdata <= host_wdata;
            end
            host_rvalid <= rd_cap;
            if (rd_cap)
                host_rdata <= dram_dq_in;
        end
    end

    // strobe outputs
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = ALL_HI;
        dram_we_n  = 1'b1;
        dram_addr  = '0;
        dram_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRECHARGE: ;
            ST_ROW_OPEN: begin
                dram_ras_n = 1'b0;
                dram_addr  = MUX_W'(open_row);
            end
            ST_COL: begin
                dram_ras_n = 1'b0;
                dram_cas_n = op_we ? ~op_be : '0;
                dram_we_n  = !op_we;
                dram_addr  = MUX_W'(op_col);
                dram_dq_oe = op_we;
            end
            ST_PAGE: begin
                dram_ras_n = 1'b0;
                dram_addr  = MUX_W'(op_col);
            end
            ST_REF_SETUP: dram_cas_n = '0;
            ST_REF_ACTIVE: begin
                dram_ras_n = 1'b0;
                dram_cas_n = '0;
            end
            default: ;
        endcase
    end

    assign dram_dq_out = op_wdata;

    AST_ROW_AGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (ras_age < AW'(T_RASP_MAX))); // R11
    AST_RAS_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (ras_age >= AW'(T_RAS))); // R9
    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && $past(dram_cas_n) == ALL_HI && dram_cas_n != ALL_HI)
        |-> (dram_we_n == !op_we)); // R5
    AST_WE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && $past(dram_cas_n) != ALL_HI && dram_cas_n != ALL_HI)
        |-> $stable(dram_we_n)); // R5
    AST_RAS_FALL_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (dram_cas_n == ALL_HI || dram_cas_n == '0)); // R12
    AST_ACK_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (dram_ras_n && dram_cas_n == ALL_HI)); // R12
    AST_READ_AFTER_RAC: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> (ras_age >= AW'(T_RAC))); // R6
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid); // R6
endmodule

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
    localparam int B_RCD = 4, B_RP = 8, B_RAS = 12, B_RC = 22, B_RAC = 12;
    localparam int B_CRD = 6, B_CWR = 3, B_CP = 2, B_PC = 8, B_CRS = 2;
    localparam int B_RMAX = 200;

    typedef struct packed {
        logic        we;
        logic [3:0]  be;
        logic [19:0] addr;
        logic [31:0] wdata;
    } acc_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_valid = 1'b0, host_we = 1'b0, ref_req = 1'b0;
    logic [19:0] host_addr = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic host_ready, host_rvalid, ref_ack, dram_ras_n, dram_we_n, dram_dq_oe;
    logic [31:0] host_rdata, dram_dq_out;
    logic [3:0]  dram_cas_n;
    logic [9:0]  dram_addr;
    logic [31:0] dev_rd = 32'hDEAD_BEEF;

    int total = 0, bad = 0, cyc = 0;
    int ras_falls = 0, ras_rises = 0;
    acc_t acc_q[$];
    logic [31:0] rd_q[$];
    logic [31:0] ref_mem [int];
    logic [31:0] dev_mem [int];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpm_dram_ctrl #(
        .T_RCD(B_RCD), .T_RP(B_RP), .T_RAS(B_RAS), .T_RC(B_RC), .T_RAC(B_RAC),
        .T_CAS_RD(B_CRD), .T_CAS_WR(B_CWR), .T_CP(B_CP), .T_PC(B_PC),
        .T_CRS(B_CRS), .T_RASP_MAX(B_RMAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_addr(host_addr), .host_we(host_we), .host_be(host_be),
        .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .ref_req(ref_req), .ref_ack(ref_ack), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dev_rd)
    );

    function automatic logic [31:0] init_word(input int a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // array model and strobe timing monitor, sampled at the falling clock edge
    logic       p_ras = 1'b1;
    logic [3:0] p_cas = 4'hF;
    logic [9:0] dev_row = '0, dev_col = '0;
    int t_rfall = -1000, t_rrise = -1000, t_cfall = -1000, t_crise = -1000, t_call = -1000;
    always @(negedge clk) begin
        if (rst_n) begin
            // column strobes all low start (refresh setup)
            if (p_cas != 4'h0 && dram_cas_n == 4'h0 && dram_ras_n) t_call = cyc;
            if (p_ras && !dram_ras_n) begin
                chk((cyc - t_rrise) >= B_RP, "R9 precharge width", 32'(cyc - t_rrise), B_RP);
                chk((cyc - t_rfall) >= B_RC, "R9 row cycle", 32'(cyc - t_rfall), B_RC);
                if (dram_cas_n == 4'h0)
                    chk((cyc - t_call) >= B_CRS, "R12 column-before-row setup", 32'(cyc - t_call), B_CRS);
                else
                    dev_row = dram_addr;
                t_rfall = cyc;
                ras_falls++;
            end
            if (!p_ras && dram_ras_n) begin
                chk((cyc - t_rfall) >= B_RAS, "R9 row strobe width", 32'(cyc - t_rfall), B_RAS);
                chk((cyc - t_rfall) < B_RMAX, "R11 row active limit", 32'(cyc - t_rfall), B_RMAX);
                t_rrise = cyc;
                ras_rises++;
            end
            if (!dram_ras_n && p_ras == 1'b0 && p_cas == 4'hF && dram_cas_n != 4'hF) begin
                if (t_cfall > t_rfall) begin
                    chk((cyc - t_cfall) >= B_PC, "R10 page cycle", 32'(cyc - t_cfall), B_PC);
                    chk((cyc - t_crise) >= B_CP, "R10 column precharge", 32'(cyc - t_crise), B_CP);
                end else begin
                    chk((cyc - t_rfall) >= B_RCD, "R3 row to column delay", 32'(cyc - t_rfall), B_RCD);
                end
                t_cfall = cyc;
                dev_col = dram_addr;
                if (acc_q.size() == 0) begin
                    chk(0, "R2 unexpected column access", 32'(dram_addr), 0);
                end else begin
                    acc_t e;
                    e = acc_q.pop_front();
                    chk(dev_row == e.addr[19:10], "R2 row address", 32'(dev_row), 32'(e.addr[19:10]));
                    chk(dram_addr == e.addr[9:0], "R2 column address", 32'(dram_addr), 32'(e.addr[9:0]));
                    chk(dram_we_n == !e.we, "R5 write strobe at column fall", 32'(dram_we_n), 32'(!e.we));
                    chk(dram_dq_oe == e.we, "R5 output enable", 32'(dram_dq_oe), 32'(e.we));
                    chk(dram_cas_n == (e.we ? ~e.be : 4'h0), "R4 lane strobes", 32'(dram_cas_n),
                        32'(e.we ? ~e.be : 4'h0));
                    if (e.we)
                        chk(dram_dq_out == e.wdata, "R5 write data", dram_dq_out, e.wdata);
                end
                begin
                    int key;
                    logic [31:0] w;
                    key = int'({dev_row, dram_addr});
                    w = dev_mem.exists(key) ? dev_mem[key] : init_word(key);
                    if (!dram_we_n) begin
                        for (int i = 0; i < 4; i++)
                            if (!dram_cas_n[i]) w[8*i +: 8] = dram_dq_out[8*i +: 8];
                        dev_mem[key] = w;
                    end else begin
                        dev_rd = w;
                    end
                end
            end else if (!dram_ras_n && !p_ras && p_cas != 4'hF && dram_cas_n != 4'hF && p_cas != 4'h0) begin
                chk(dram_we_n == p_we, "R5 write strobe held", 32'(dram_we_n), 32'(p_we));
            end
            if (p_cas != 4'hF && dram_cas_n == 4'hF) t_crise = cyc;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_we  = dram_we_n;
        end
    end
    logic p_we = 1'b1;

    // read scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (rd_q.size() == 0)
                chk(0, "R6 unexpected read data", host_rdata, 0);
            else begin
                logic [31:0] x;
                x = rd_q.pop_front();
                chk(host_rdata == x, "R6 R2 read data", host_rdata, x);
            end
        end
    end

    // driver: issue one host request and push expectations
    task automatic access(input logic [19:0] a, input logic we, input logic [3:0] be, input logic [31:0] d);
        acc_t e;
        int key;
        logic [31:0] w;
        @(negedge clk);
        host_valid = 1'b1; host_addr = a; host_we = we; host_be = be; host_wdata = d;
        #1;
        while (!host_ready) begin
            @(negedge clk);
            #1;
        end
        e.we = we; e.be = we ? be : 4'h0; e.addr = a; e.wdata = d;
        acc_q.push_back(e);
        key = int'(a);
        w = ref_mem.exists(key) ? ref_mem[key] : init_word(key);
        if (we) begin
            for (int i = 0; i < 4; i++)
                if (be[i]) w[8*i +: 8] = d[8*i +: 8];
            ref_mem[key] = w;
        end else begin
            rd_q.push_back(w);
        end
        @(posedge clk);
        #1 host_valid = 1'b0;
    endtask

    task automatic refresh();
        @(negedge clk);
        ref_req = 1'b1;
        #1;
        while (!ref_ack) begin
            chk(!host_ready, "R12 ready low while refresh pending", 32'(host_ready), 0);
            @(negedge clk);
            #1;
        end
        chk(dram_ras_n && dram_cas_n == 4'hF, "R12 R13 ack with row closed", {27'd0, dram_ras_n, dram_cas_n}, 32'h1F);
        @(posedge clk);
        #1 ref_req = 1'b0;
        @(negedge clk);
        chk(dram_cas_n == 4'h0 && dram_ras_n, "R12 refresh setup strobes", {27'd0, dram_ras_n, dram_cas_n}, 32'h10);
        chk(!ref_ack, "R12 ack is a pulse", 32'(ref_ack), 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int rf0, rr0;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n == 4'hF && dram_we_n && !dram_dq_oe, "R1 strobes in reset",
            {26'd0, dram_ras_n, dram_cas_n, dram_we_n}, 32'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n == 1'b1, "R1 row strobe", 32'(dram_ras_n), 1);
        chk(dram_cas_n == 4'hF, "R1 column strobes", 32'(dram_cas_n), 32'hF);
        chk(dram_we_n == 1'b1 && dram_dq_oe == 1'b0, "R1 write strobe and enable", {30'd0, dram_we_n, dram_dq_oe}, 32'h2);
        chk(host_ready == 1'b1 && host_rvalid == 1'b0, "R1 host side", {30'd0, host_ready, host_rvalid}, 32'h2);

        // full write then read, same row
        access(20'h01403, 1'b1, 4'hF, 32'hCAFE_F00D);
        access(20'h01403, 1'b0, 4'h0, 32'h0);
        // page hits: byte-masked write and read back, no new row strobe
        rf0 = ras_falls;
        access(20'h01404, 1'b1, 4'b0101, 32'h1122_3344);
        access(20'h01404, 1'b0, 4'h0, 32'h0);
        access(20'h01403, 1'b0, 4'h0, 32'h0);
        idle(12);
        chk(ras_falls == rf0, "R7 page hit keeps row open", 32'(ras_falls), 32'(rf0));
        // row miss
        rr0 = ras_rises;
        access(20'h02405, 1'b0, 4'h0, 32'h0);
        idle(16);
        chk(ras_falls == rf0 + 1, "R8 single reopen on miss", 32'(ras_falls), 32'(rf0 + 1));
        chk(ras_rises == rr0 + 1, "R8 row closed on miss", 32'(ras_rises), 32'(rr0 + 1));
        for (int b = 1; b < 16; b++) begin
            access(20'h02405, 1'b1, 4'(b), 32'h0101_0101 * b);
            access(20'h02405, 1'b0, 4'h0, 32'h0);
        end
        // refresh with a page open, then from idle
        refresh();
        idle(30);
        refresh();
        idle(30);
        // address extremes
        access(20'hFFFFF, 1'b1, 4'hF, 32'h8765_4321);
        access(20'h4B3FF, 1'b1, 4'b1000, 32'hA5A5_A5A5);
        access(20'hFFFFF, 1'b0, 4'h0, 32'h0);
        access(20'h4B3FF, 1'b0, 4'h0, 32'h0);
        access(20'h00000, 1'b0, 4'h0, 32'h0);
        // leave a row open with no traffic
        rr0 = ras_rises;
        access(20'h13000, 1'b0, 4'h0, 32'h0);
        idle(B_RMAX + 40);
        chk(dram_ras_n == 1'b1, "R11 idle row closed", 32'(dram_ras_n), 1);
        chk(ras_rises == rr0 + 2, "R11 self close happened", 32'(ras_rises), 32'(rr0 + 2));
        idle(20);
        chk(rd_q.size() == 0, "R6 all reads returned", 32'(rd_q.size()), 0);
        chk(acc_q.size() == 0, "R2 all accesses seen", 32'(acc_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule